// File: doc/BRIEF.md
# Retired Instruction Counter CSR

This block keeps a 64-bit count of the instructions the pipeline retires. Software sees the count as two 32-bit machine CSRs, one for the low word and one for the high word, plus an inhibit CSR. The inhibit CSR can freeze counting. The pipeline gives one retire pulse for each completed instruction, however many cycles that instruction took. A CSR port (address, read strobe, write strobe, write data) serves the instruction being executed, and the read data comes back combinationally in the same cycle.

The main task of the block is to define how a software write combines with the increment from the writing instruction's own retirement. The written word takes the written value and skips that increment. The other word still receives its share of the increment, and this includes a carry out of the low word's old value.

Top module: `instret_csr`

## Requirements
- R1: After reset the low word, high word and inhibit CSR all read 0.
- R2: A read with the read strobe high and a matching address returns the register value held in that cycle. Without the strobe, or at any other address, the read data is 0. The addresses are 0xB02 for the low word, 0xB82 for the high word and 0x320 for inhibit.
- R3: Each retire pulse adds exactly one to the 64-bit count while counting is enabled. Cycles without a pulse leave the count unchanged, so a multi-cycle instruction counts once.
- R4: A write to the low word loads the written value and is not incremented by the writing instruction's retirement. A clear followed by two back-to-back reads returns 0 and then 1.
- R5: When the low word is written in a cycle where an enabled retirement meets an old low value of 0xFFFFFFFF, the high word is still incremented by one.
- R6: A write to the high word loads the written value, and the low word still increments on that retirement. Starting from low 0xFFFFFFFE, a high write of 0xFFFFFFFF leaves low 0xFFFFFFFF and high 0xFFFFFFFF.
- R7: The 64-bit count wraps from all ones to zero.
- R8: Inhibit bit 2 set to 1 stops all increments, so a clear followed by two reads returns 0 and 0. Only bit 2 is stored, and every other inhibit bit reads 0. A write to the inhibit CSR first applies to the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | One-cycle pulse per retired instruction |
| csr_addr_i | input | 12 | CSR address |
| csr_rd_i | input | 1 | CSR read strobe |
| csr_wr_i | input | 1 | CSR write strobe, in the writing instruction's retire cycle |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data, combinational |

## Verification
A wrong count appears as a wrong read value on the next instruction that reads the affected word. This happens at the latest one cycle after the faulty update, because reads show the register contents of their own cycle. A lost carry only shows in the high word, so the carry and wrap scenarios read the high word twice and then read the low word. A stuck or leaky inhibit bit shows as a difference between two back-to-back reads of the low word.

// File: rtl/instret_csr.sv
module instret_csr #(
  parameter int          XLEN     = 32,
  parameter int          AW       = 12,
  parameter logic [11:0] LO_ADDR  = 12'hB02,
  parameter logic [11:0] HI_ADDR  = 12'hB82,
  parameter logic [11:0] INH_ADDR = 12'h320,
  parameter int          INH_BIT  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_i,
  input  logic [AW-1:0]   csr_addr_i,
  input  logic            csr_rd_i,
  input  logic            csr_wr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o
);
  localparam int CW = 2 * XLEN;
  localparam logic [XLEN-1:0] ONES = '1;

  logic [XLEN-1:0] lo_q, hi_q;
  logic            inh_q;
  logic [CW-1:0]   sum;
  logic            inc, wr_lo, wr_hi, wr_inh;

  assign inc    = retire_i && !inh_q;
  assign sum    = {hi_q, lo_q} + {{(CW-1){1'b0}}, inc};
  assign wr_lo  = csr_wr_i && (csr_addr_i == LO_ADDR);
  assign wr_hi  = csr_wr_i && (csr_addr_i == HI_ADDR);
  assign wr_inh = csr_wr_i && (csr_addr_i == INH_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      inh_q <= 1'b0;
    end else begin
      lo_q <= wr_lo ? csr_wdata_i : sum[XLEN-1:0];
      hi_q <= wr_hi ? csr_wdata_i : sum[CW-1:XLEN];
      if (wr_inh) inh_q <= csr_wdata_i[INH_BIT];
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    if (csr_rd_i) begin
      if (csr_addr_i == LO_ADDR)       csr_rdata_o = lo_q;
      else if (csr_addr_i == HI_ADDR)  csr_rdata_o = hi_q;
      else if (csr_addr_i == INH_ADDR) csr_rdata_o[INH_BIT] = inh_q;
    end
  end

  // R4: written low word holds exactly the written value
  assert_lo_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(csr_wdata_i));

  // R5: carry out of an old all-ones low word survives a low write
  assert_carry_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && inc && lo_q == ONES) |=> hi_q == $past(hi_q) + 1'b1);

  // R6: high write does not block the low increment
  assert_hi_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && inc) |=> (hi_q == $past(csr_wdata_i)) && (lo_q == $past(lo_q) + 1'b1));

  // R8: inhibited counter only changes through writes
  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inh_q && !wr_lo && !wr_hi) |=> $stable(lo_q) && $stable(hi_q));

  // R3: no retire, no write -> count stable
  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !wr_lo && !wr_hi) |=> $stable(lo_q) && $stable(hi_q));

  // R2: other inhibit bits never read as one
  assert_inh_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_i && csr_addr_i == INH_ADDR) |-> $countones(csr_rdata_o) <= 1);
endmodule

// File: tb/instret_csr_test.sv
module instret_csr_test;
  localparam logic [11:0] A_LO = 12'hB02, A_HI = 12'hB82, A_INH = 12'h320;

  logic clk = 0, rst_n = 0, retire = 0, rd = 0, wr = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, fails = 0;
  logic [31:0] r0, r1, r2;

  always #4 clk = ~clk;

  instret_csr uut (.clk(clk), .rst_n(rst_n), .retire_i(retire), .csr_addr_i(addr),
    .csr_rd_i(rd), .csr_wr_i(wr), .csr_wdata_i(wdata), .csr_rdata_o(rdata));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, sample read data before posedge
  task automatic cyc(input logic ret, input logic r, input logic w, input logic [11:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    retire = ret; rd = r; wr = w; addr = a; wdata = d;
    #1 q = rdata;
    @(posedge clk);
    #1 retire = 0; rd = 0; wr = 0;
  endtask

  task automatic csrw(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] q;
    cyc(1, 0, 1, a, d, q);
  endtask

  task automatic csrr(input logic [11:0] a, output logic [31:0] q);
    cyc(1, 1, 0, a, 32'h0, q);
  endtask

  task automatic stall(input int n);
    logic [31:0] q;
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 12'h0, 32'h0, q);
  endtask

  task automatic t_reset;
    logic [31:0] q;
    cyc(0, 1, 0, A_LO, 0, q);  check("R1 lo", q, 0);
    cyc(0, 1, 0, A_HI, 0, q);  check("R1 hi", q, 0);
    cyc(0, 1, 0, A_INH, 0, q); check("R1 inh", q, 0);
  endtask

  task automatic t_clear_read;
    csrw(A_LO, 32'h0);
    csrr(A_LO, r0); csrr(A_LO, r1);
    check("R4 first", r0, 0); check("R4 second", r1, 1);
  endtask

  task automatic t_multicycle;
    csrw(A_LO, 32'h0);
    csrw(12'h0, 0);        // non-CSR instruction retiring
    stall(5); csrw(12'h0, 0);
    stall(2); csrw(12'h0, 0);
    csrw(12'h0, 0);
    csrr(A_LO, r0);
    check("R3 count", r0, 4);
  endtask

  task automatic t_read_mux;
    logic [31:0] q;
    cyc(0, 0, 0, A_LO, 0, q); check("R2 no strobe", q, 0);
    cyc(0, 1, 0, 12'h123, 0, q); check("R2 bad addr", q, 0);
  endtask

  task automatic t_carry;
    csrw(A_LO, 0); csrw(A_HI, 0);
    for (int i = 0; i < 5; i++) csrw(A_LO, 32'hFFFF_FFFF);
    csrr(A_HI, r0); csrr(A_HI, r1); csrr(A_LO, r2);
    check("R5 hi a", r0, 4); check("R5 hi b", r1, 5); check("R5 lo", r2, 1);
  endtask

  task automatic t_wrap;
    csrw(A_LO, 0); csrw(A_HI, 0);
    csrw(A_LO, 32'hFFFF_FFFE); csrw(A_HI, 32'hFFFF_FFFF);
    csrr(A_HI, r0); csrr(A_HI, r1); csrr(A_LO, r2);
    check("R6 hi", r0, 32'hFFFF_FFFF);
    check("R7 hi wrap", r1, 0); check("R7 lo", r2, 1);
  endtask

  task automatic t_inhibit;
    csrw(A_INH, 32'h4);
    csrw(A_LO, 0); csrr(A_LO, r0); csrr(A_LO, r1);
    check("R8 inh a", r0, 0); check("R8 inh b", r1, 0);
    csrw(A_INH, 32'hFFFF_FFFF); csrr(A_INH, r0);
    check("R8 mask", r0, 32'h4);
    csrw(A_INH, 32'hFFFF_FFFB); csrr(A_INH, r0);
    check("R8 bit2 clear", r0, 0);
    csrw(A_LO, 0); csrr(A_LO, r0); csrr(A_LO, r1);
    check("R8 resume a", r0, 0); check("R8 resume b", r1, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset; t_read_mux; t_clear_read; t_multicycle;
    t_carry; t_wrap; t_inhibit;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule